// File: doc/BRIEF.md
# Sum of Absolute Differences Engine

This engine computes the sum of absolute differences between two equal-length blocks of 32-bit words. Both blocks sit in one attached single-port synchronous memory. The engine is the master on that memory. It sets a read-enable and an address, then expects an acknowledge together with the read data in the cycle that follows. If no acknowledge comes back, the address lies outside the memory. The engine then stops, and it reports the failure rather than using the data word.

Software or a sequencer starts a computation with a one-cycle `start_i` pulse. The engine then walks the index from zero to the block length minus one. For each index it reads the first-block word, then the second-block word, and forms their difference in 33-bit signed arithmetic. It takes the magnitude of that difference and adds it to an accumulator. The subtract, the magnitude step and the add each take one clock cycle. At the end, `done_o` pulses for one cycle. When the run has failed, `err_o` pulses in that same cycle.

The memory side has no back-pressure. A request is held for exactly two cycles, and an acknowledge that is missing in the second cycle is final. The block length and the two base addresses are elaboration-time parameters.

Top module: `sad_engine`

## Requirements
- R1: After reset, `rd_en_o`, `done_o` and `err_o` are 0 and `result_o` is 0.
- R2: A `start_i` pulse seen while idle starts a run. For each index i (0 to LEN-1), the engine reads address BASE_A+i and then address BASE_B+i, in that order. The defaults are LEN=64, BASE_A=0 and BASE_B=64.
- R3: Each read holds `rd_en_o` high and `rd_addr_o` steady for exactly two cycles: the request cycle and the following acknowledge cycle. The memory's response registered on the request cycle's edge is sampled in the acknowledge cycle.
- R4: Each difference is formed as the 33-bit signed value A − B from zero-extended operands. Its magnitude is added, so an operand pair of 0xFFFFFFFF and 0 contributes 0xFFFFFFFF in either order.
- R5: The accumulator starts at 0. `result_o` equals the sum of all LEN magnitudes modulo 2^32 in the cycle where `done_o` is 1.
- R6: If `rd_ack_i` is 0 in an acknowledge cycle, the next cycle has `done_o`=1 and `err_o`=1, and no further reads are issued.
- R7: A `start_i` pulse while a run is in progress has no effect on the read sequence or on completion timing.
- R8: `done_o` is a one-cycle pulse. After a successful run, `result_o` stays constant until the next start.
- R9: Each element takes 7 cycles: four read cycles, then subtract, magnitude and accumulate. `done_o` rises in the cycle after the last accumulate, which is LEN·7+1 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Failure flag, valid with `done_o` |
| result_o | output | DATA_W | Accumulated sum |
| rd_en_o | output | 1 | Memory read enable |
| rd_addr_o | output | ADDR_W | Memory read address |
| rd_data_i | input | DATA_W | Memory read data, valid with `rd_ack_i` |
| rd_ack_i | input | 1 | Memory acknowledge, one cycle after the request |

## Verification
The first input pattern is pseudo-random block contents. It exercises the general mix of positive and negative differences and the ordering of the addresses. Identical blocks must give zero, which separates a true subtract from a path that adds operands. Blocks of all ones against all zeros, run in both directions, expose any 32-bit difference that overflows or a magnitude step that acts on only one sign, and the 64-fold sum also checks the wrap modulo 2^32. Memory limits placed inside the second block and inside the first block check that a failure stops the run at the first missing acknowledge in each read phase. A later clean run confirms that the failure flag does not persist.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B,
    ST_SUB,
    ST_ABS,
    ST_ACC,
    ST_DONE
  } sad_state_e;
endpackage

// File: rtl/sad_addr_gen.sv
module sad_addr_gen #(
  parameter int LEN    = 64,
  parameter int BASE_A = 0,
  parameter int BASE_B = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              sel_b_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign last_o = (idx_q == IDX_W'(LEN - 1));
  assign addr_o = (sel_b_i ? ADDR_W'(BASE_B) : ADDR_W'(BASE_A)) + ADDR_W'(idx_q);
endmodule

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  input  logic last_i,
  output logic rd_en_o,
  output logic sel_b_o,
  output logic clr_o,
  output logic cap_a_o,
  output logic cap_b_o,
  output logic do_sub_o,
  output logic do_abs_o,
  output logic do_acc_o,
  output logic done_o,
  output logic err_o,
  output logic waiting_o,
  output logic idle_o
);
  sad_state_e st_q, st_d;
  logic       err_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_REQ_A;
      ST_REQ_A:  st_d = ST_WAIT_A;
      ST_WAIT_A: st_d = ack_i ? ST_REQ_B : ST_DONE;
      ST_REQ_B:  st_d = ST_WAIT_B;
      ST_WAIT_B: st_d = ack_i ? ST_SUB : ST_DONE;
      ST_SUB:    st_d = ST_ABS;
      ST_ABS:    st_d = ST_ACC;
      ST_ACC:    st_d = last_i ? ST_DONE : ST_REQ_A;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  assign waiting_o = (st_q == ST_WAIT_A) || (st_q == ST_WAIT_B);
  assign idle_o    = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (idle_o && start_i)       err_q <= 1'b0;
      else if (waiting_o && !ack_i) err_q <= 1'b1;
    end
  end

  assign rd_en_o  = (st_q == ST_REQ_A) || (st_q == ST_WAIT_A) ||
                    (st_q == ST_REQ_B) || (st_q == ST_WAIT_B);
  assign sel_b_o  = (st_q == ST_REQ_B) || (st_q == ST_WAIT_B);
  assign clr_o    = idle_o && start_i;
  assign cap_a_o  = (st_q == ST_WAIT_A) && ack_i;
  assign cap_b_o  = (st_q == ST_WAIT_B) && ack_i;
  assign do_sub_o = (st_q == ST_SUB);
  assign do_abs_o = (st_q == ST_ABS);
  assign do_acc_o = (st_q == ST_ACC);
  assign done_o   = (st_q == ST_DONE);
  assign err_o    = done_o && err_q;
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic              do_sub_i,
  input  logic              do_abs_i,
  input  logic              do_acc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o
);
  localparam int DIFF_W = DATA_W + 1;

  logic [DATA_W-1:0]        a_q, b_q, acc_q;
  logic signed [DIFF_W-1:0] diff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      diff_q <= '0;
      acc_q  <= '0;
    end else begin
      if (cap_a_i) a_q <= data_i;
      if (cap_b_i) b_q <= data_i;
      if (do_sub_i)
        diff_q <= $signed({1'b0, a_q}) - $signed({1'b0, b_q});
      else if (do_abs_i && diff_q[DIFF_W-1])
        diff_q <= -diff_q;
      if (clr_i)         acc_q <= '0;
      else if (do_acc_i) acc_q <= acc_q + diff_q[DATA_W-1:0];
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sad_engine.sv
module sad_engine #(
  parameter int LEN    = 64,
  parameter int BASE_A = 0,
  parameter int BASE_B = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] result_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_ack_i
);
  logic sel_b, clr, last, cap_a, cap_b, do_sub, do_abs, do_acc;
  logic waiting, idle;

  sad_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(rd_ack_i),
    .last_i(last), .rd_en_o(rd_en_o), .sel_b_o(sel_b), .clr_o(clr),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .do_sub_o(do_sub),
    .do_abs_o(do_abs), .do_acc_o(do_acc), .done_o(done_o),
    .err_o(err_o), .waiting_o(waiting), .idle_o(idle)
  );

  sad_addr_gen #(
    .LEN(LEN), .BASE_A(BASE_A), .BASE_B(BASE_B), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .step_i(do_acc),
    .sel_b_i(sel_b), .addr_o(rd_addr_o), .last_o(last)
  );

  sad_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cap_a_i(cap_a),
    .cap_b_i(cap_b), .do_sub_i(do_sub), .do_abs_i(do_abs),
    .do_acc_i(do_acc), .data_i(rd_data_i), .acc_o(result_o)
  );
endmodule

// File: rtl/sad_engine_chk.sv
module sad_engine_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic              err_o,
  input logic [DATA_W-1:0] result_o,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              waiting,
  input logic              idle
);
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: failure flag only appears with completion
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R6: missing acknowledge ends the run with a failure
  a_r6_noack_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !rd_ack_i) |=> (done_o && err_o && !rd_en_o));

  // R3: a new request keeps its address for the acknowledge cycle
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_o && !waiting) |=> (rd_en_o && $stable(rd_addr_o)));

  // R8: result is held while idle without a start
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start_i) |=> $stable(result_o));

  // R9: no read issued in the completion cycle
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_en_o);
endmodule

bind sad_engine sad_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .err_o(err_o), .result_o(result_o), .rd_en_o(rd_en_o),
  .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .waiting(waiting), .idle(idle)
);

// File: tb/sad_engine_tb_top.sv
module sad_engine_tb_top;
  localparam int LEN = 64, BA = 0, BB = 64, MEMW = 128;

  typedef struct {
    bit          en;
    int unsigned addr;
    bit          done;
    bit          err;
    bit          chk_res;
    logic [31:0] res;
    string       tag;
  } exp_t;

  logic        clk = 0, rst_n = 0, start = 0;
  logic        done, err, rd_en, rd_ack;
  logic [31:0] result, rd_addr, rd_data;
  logic [31:0] mem [MEMW];
  int unsigned lim = MEMW;
  int          n_chk = 0, n_fail = 0;
  bit          armed = 0, held_ok = 0;
  logic [31:0] held = '0;
  exp_t        exp_q[$];

  always #5 clk = ~clk;

  sad_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .err_o(err),
    .result_o(result), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .rd_ack_i(rd_ack)
  );

  // memory model: answers one cycle after a request
  always_ff @(posedge clk) begin
    rd_ack  <= rd_en && (rd_addr < lim);
    rd_data <= (rd_addr < lim) ? mem[rd_addr[6:0]] : 32'hDEAD_BEEF;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic push(input bit en, input int unsigned a, input bit d,
                      input bit e, input bit cr, input logic [31:0] r, input string tag);
    exp_t x;
    x.en = en; x.addr = a; x.done = d; x.err = e; x.chk_res = cr; x.res = r; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // behavioural schedule built from the requirements
  task automatic build;
    longint sum = 0;
    push(0, 0, 0, 0, held_ok, held, "R8");
    for (int i = 0; i < LEN; i++) begin
      longint d;
      push(1, BA + i, 0, 0, 0, 0, "R2");
      push(1, BA + i, 0, 0, 0, 0, "R3");
      if (BA + i >= lim) begin push(0, 0, 1, 1, 0, 0, "R6"); return; end
      push(1, BB + i, 0, 0, 0, 0, "R2");
      push(1, BB + i, 0, 0, 0, 0, "R3");
      if (BB + i >= lim) begin push(0, 0, 1, 1, 0, 0, "R6"); return; end
      for (int k = 0; k < 3; k++) push(0, 0, 0, 0, 0, 0, "R9");
      d = longint'(mem[BA + i]) - longint'(mem[BB + i]);
      if (d < 0) d = -d;
      sum += d;
    end
    push(0, 0, 1, 0, 1, sum[31:0], "R5");
  endtask

  always @(negedge clk) begin
    if (armed) begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin
        e.en = 0; e.addr = 0; e.done = 0; e.err = 0;
        e.chk_res = held_ok; e.res = held; e.tag = "R8";
      end
      chk(rd_en === e.en, e.tag, "rd_en", {31'b0, rd_en}, {31'b0, e.en});
      if (e.en) chk(rd_addr === e.addr, e.tag, "rd_addr", rd_addr, e.addr);
      chk(done === e.done, e.tag, "done", {31'b0, done}, {31'b0, e.done});
      chk(err === e.err, "R6", "err", {31'b0, err}, {31'b0, e.err});
      if (e.chk_res) chk(result === e.res, e.tag, "result", result, e.res);
      if (e.done) begin held_ok = !e.err; held = e.res; end
    end
  end

  task automatic run(input bit poke_busy);
    @(posedge clk); #1 start = 1; build();
    @(posedge clk); #1 start = 0;
    if (poke_busy) begin  // R7: start while busy is ignored
      repeat (20) @(posedge clk);
      #1 start = 1;
      @(posedge clk); #1 start = 0;
    end
    wait (exp_q.size() == 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic fill(input int mode);
    int unsigned s = 32'h1234_5678;
    for (int i = 0; i < MEMW; i++) begin
      s = s * 1103515245 + 12345;
      case (mode)
        0: mem[i] = s;
        1: mem[i] = 32'hA5A5_0000 + (i % 64);
        2: mem[i] = (i < 64) ? 32'hFFFF_FFFF : 32'h0;
        default: mem[i] = (i < 64) ? 32'h0 : 32'hFFFF_FFFF;
      endcase
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    fill(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk(rd_en === 0 && done === 0 && err === 0, "R1", "ctrl", {29'b0, rd_en, done, err}, 0);
    chk(result === 0, "R1", "result", result, 0);
    @(posedge clk); #1 rst_n = 1; armed = 1;
    repeat (2) @(posedge clk);
    run(1);            // R2 R7 random data
    fill(1); run(0);   // identical blocks -> 0
    fill(2); run(0);   // R4 ones minus zeros, wraps
    fill(3); run(1);   // R4 zeros minus ones
    fill(0); lim = 100; run(0);  // R6 failure in second block
    lim = 20; run(0);            // R6 failure in first block
    lim = MEMW; run(0);          // clean run after failures
    summary();
  end
endmodule